// File: doc/BRIEF.md
# TPM SPI Register Transaction Sequencer

This block is an SPI master that carries out one register read or one register write to a TPM-style SPI target. A request gives a direction, a 16-bit register address and a length in bytes. Once a request is accepted, the block drives chip select low, shifts out a four-byte command header and reads the target's reply to the last header byte. If the target asks for a wait state, the block polls it with zero bytes for a bounded number of bytes. It then moves the payload and releases chip select.

Write payload enters through a valid/ready byte port. Read payload leaves through a byte port with a valid strobe. At the end of every request the block gives a single-cycle done strobe with a 2-bit status. Status codes: 2'b00 success, 2'b01 bad length, 2'b10 wait-state timeout. The serial link runs in mode 0, most significant bit first. The SCLK half-period is `CLK_DIV` system cycles.

Top module: `tpm_spi_txn`

## Requirements
- R1: Header byte 0 carries the direction in bit 7 (1 = read, 0 = write) and the length minus one in bits 6:0.
- R2: Header bytes 1, 2 and 3 are the constant 0xD4, the address high byte and the address low byte. Every byte is sent MSB first, and MOSI never changes at a rising SCLK edge.
- R3: A request with a length of 0 or greater than `MAX_LEN` (128) ends with done and status 2'b01. Chip select stays high and SCLK does not toggle.
- R4: If bit 0 of the byte received during header byte 3 is 1, the payload phase starts at once, with no poll byte.
- R5: Otherwise the block sends 0x00 poll bytes and checks bit 0 of each reply, ignoring the other bits. It enters the payload phase right after the first reply whose bit 0 is 1.
- R6: After `MAX_POLLS` (50) poll replies that all have bit 0 clear, the request ends with done and status 2'b10, chip select released, and no payload byte sent.
- R7: A write takes exactly `length` bytes through the wr_valid/wr_ready handshake and sends them in order after the header and poll bytes.
- R8: A read sends 0x00 for each payload byte and presents exactly `length` received bytes, in order, each with a one-cycle rd_valid.
- R9: Chip select goes low before the first SCLK rising edge of a request and rises in the same cycle as done. SCLK is low whenever chip select is high.
- R10: A request that completes gives a single-cycle done with status 2'b00. req_ready is high only while no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Target register address |
| req_len | input | 8 | Payload length in bytes |
| req_ready | output | 1 | Block idle, request can be taken |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload byte available |
| wr_ready | output | 1 | Block takes wr_data this cycle |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | rd_data valid for one cycle |
| done | output | 1 | One-cycle end-of-request strobe |
| status | output | 2 | Result code, valid with done |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to target |
| miso | input | 1 | Serial data from target |

## Verification
The bench builds the block with `CLK_DIV` = 2 and `MAX_POLLS` = 6. With a poll limit this short, the case where the last permitted poll succeeds and the case where the timeout fires cost only a few hundred cycles each. A divider above one exercises the SCLK half-period counter. `MAX_LEN` stays at 128, so a full 128-byte write and the 129-byte rejection can both be run. The target model returns 0xFE as the not-ready reply, so any bit other than bit 0 that leaks into the poll decision shows up as a mismatch.

// File: rtl/tpm_spi_pkg.sv
package tpm_spi_pkg;

    localparam int unsigned LEN_W     = 8;
    localparam int unsigned ADDR_W    = 16;
    localparam int unsigned HDR_BYTES = 4;
    localparam logic [7:0]  HDR_PREFIX = 8'hD4;

    typedef enum logic [1:0] {
        ST_OK      = 2'b00,
        ST_BADLEN  = 2'b01,
        ST_TIMEOUT = 2'b10
    } txn_status_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HDR,
        PH_POLL,
        PH_DATA
    } txn_phase_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } txn_req_t;

    function automatic logic len_in_range(input logic [LEN_W-1:0] len,
                                          input int unsigned max_len);
        return (len != '0) && (int'(len) <= int'(max_len));
    endfunction

    function automatic logic [7:0] header_byte(input txn_req_t r,
                                               input logic [1:0] idx);
        logic [7:0] lm1;
        lm1 = r.len - 8'd1;
        case (idx)
            2'd0:    return {~r.write, lm1[6:0]};
            2'd1:    return HDR_PREFIX;
            2'd2:    return r.addr[15:8];
            default: return r.addr[7:0];
        endcase
    endfunction

endpackage

// File: rtl/tpm_spi_shifter.sv
module tpm_spi_shifter #(
    parameter int unsigned CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_cnt;
    logic [7:0]       tx_sh;
    logic [7:0]       rx_sh;
    logic             half_tick;

    assign half_tick = busy && (div_cnt == DIV_LAST);
    assign mosi      = tx_sh[7];
    assign rx_byte   = rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            byte_done <= 1'b0;
            div_cnt   <= '0;
            bit_cnt   <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            sclk      <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    tx_sh   <= tx_byte;
                    bit_cnt <= '0;
                    div_cnt <= '0;
                    sclk    <= 1'b0;
                end
            end else if (half_tick) begin
                div_cnt <= '0;
                if (!sclk) begin
                    // rising edge: capture target data
                    sclk  <= 1'b1;
                    rx_sh <= {rx_sh[6:0], miso};
                end else begin
                    // falling edge: advance output bit or finish byte
                    sclk <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        busy      <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                    end
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tpm_spi_seq.sv
module tpm_spi_seq
    import tpm_spi_pkg::*;
#(
    parameter int unsigned MAX_POLLS = 50,
    parameter int unsigned MAX_LEN   = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_ready,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic [1:0]        status,
    output logic              cs_n,
    output logic              sh_start,
    output logic [7:0]        sh_tx,
    input  logic              sh_done,
    input  logic [7:0]        sh_rx
);
    localparam int unsigned PW = $clog2(MAX_POLLS + 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

    txn_phase_e       phase;
    txn_req_t         req_q;
    logic [1:0]       hdr_idx;
    logic [PW-1:0]    polls;
    logic [LEN_W-1:0] data_cnt;
    logic             inflight;
    logic             last_data;

    assign req_ready = (phase == PH_IDLE);
    assign wr_ready  = (phase == PH_DATA) && req_q.write && !inflight;
    assign last_data = (data_cnt == req_q.len - 8'd1);

    always_comb begin
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        case (phase)
            PH_HDR: begin
                sh_tx    = header_byte(req_q, hdr_idx);
                sh_start = !inflight;
            end
            PH_POLL: begin
                sh_start = !inflight;
            end
            PH_DATA: begin
                if (req_q.write) begin
                    sh_tx    = wr_data;
                    sh_start = !inflight && wr_valid;
                end else begin
                    sh_start = !inflight;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            req_q    <= '0;
            hdr_idx  <= '0;
            polls    <= '0;
            data_cnt <= '0;
            inflight <= 1'b0;
            cs_n     <= 1'b1;
            done     <= 1'b0;
            status   <= ST_OK;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            if (sh_start) inflight <= 1'b1;
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        if (len_in_range(req_len, MAX_LEN)) begin
                            req_q   <= '{write: req_write, addr: req_addr, len: req_len};
                            hdr_idx <= '0;
                            cs_n    <= 1'b0;
                            phase   <= PH_HDR;
                        end else begin
                            done   <= 1'b1;
                            status <= ST_BADLEN;
                        end
                    end
                end
                PH_HDR: begin
                    if (sh_done) begin
                        inflight <= 1'b0;
                        if (hdr_idx == 2'(HDR_BYTES - 1)) begin
                            if (sh_rx[0]) begin
                                data_cnt <= '0;
                                phase    <= PH_DATA;
                            end else begin
                                polls <= '0;
                                phase <= PH_POLL;
                            end
                        end else begin
                            hdr_idx <= hdr_idx + 2'd1;
                        end
                    end
                end
                PH_POLL: begin
                    if (sh_done) begin
                        inflight <= 1'b0;
                        if (sh_rx[0]) begin
                            data_cnt <= '0;
                            phase    <= PH_DATA;
                        end else if (polls == POLL_LAST) begin
                            phase  <= PH_IDLE;
                            cs_n   <= 1'b1;
                            done   <= 1'b1;
                            status <= ST_TIMEOUT;
                        end else begin
                            polls <= polls + 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (sh_done) begin
                        inflight <= 1'b0;
                        if (!req_q.write) begin
                            rd_valid <= 1'b1;
                            rd_data  <= sh_rx;
                        end
                        if (last_data) begin
                            phase  <= PH_IDLE;
                            cs_n   <= 1'b1;
                            done   <= 1'b1;
                            status <= ST_OK;
                        end else begin
                            data_cnt <= data_cnt + 8'd1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tpm_spi_txn.sv
module tpm_spi_txn
    import tpm_spi_pkg::*;
#(
    parameter int unsigned CLK_DIV   = 4,
    parameter int unsigned MAX_POLLS = 50,
    parameter int unsigned MAX_LEN   = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_len,
    output logic        req_ready,
    input  logic [7:0]  wr_data,
    input  logic        wr_valid,
    output logic        wr_ready,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    output logic        done,
    output logic [1:0]  status,
    output logic        cs_n,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso
);
    logic       sh_start;
    logic [7:0] sh_tx;
    logic       sh_busy;
    logic       sh_done;
    logic [7:0] sh_rx;

    tpm_spi_seq #(
        .MAX_POLLS (MAX_POLLS),
        .MAX_LEN   (MAX_LEN)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_ready (req_ready),
        .wr_data   (wr_data),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .done      (done),
        .status    (status),
        .cs_n      (cs_n),
        .sh_start  (sh_start),
        .sh_tx     (sh_tx),
        .sh_done   (sh_done),
        .sh_rx     (sh_rx)
    );

    tpm_spi_shifter #(
        .CLK_DIV (CLK_DIV)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (sh_start),
        .tx_byte   (sh_tx),
        .busy      (sh_busy),
        .byte_done (sh_done),
        .rx_byte   (sh_rx),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso)
    );
endmodule

// File: rtl/tpm_spi_txn_chk.sv
module tpm_spi_txn_chk #(
    parameter int unsigned MAX_LEN = 128
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [7:0] req_len,
    input logic       req_ready,
    input logic       wr_ready,
    input logic       done,
    input logic [1:0] status,
    input logic       cs_n,
    input logic       sclk,
    input logic       mosi
);
    logic len_bad;
    assign len_bad = (req_len == 8'd0) || (int'(req_len) > int'(MAX_LEN));

    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(mosi));

    p_bad_len_r3: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid && len_bad) |=> (done && status == 2'b01 && cs_n));

    p_sclk_idle_r9: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    p_cs_start_r9: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid && !len_bad) |=> !cs_n);

    p_cs_release_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> cs_n);

    p_wr_in_txn_r7: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> !cs_n);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_status_code_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (status != 2'b11));
endmodule

bind tpm_spi_txn tpm_spi_txn_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_len   (req_len),
    .req_ready (req_ready),
    .wr_ready  (wr_ready),
    .done      (done),
    .status    (status),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .mosi      (mosi)
);

// File: tb/tpm_spi_txn_tb.sv
module tpm_spi_txn_tb;
    localparam int CLK_DIV   = 2;
    localparam int MAX_POLLS = 6;
    localparam int MAX_LEN   = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic        req_ready;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        done;
    logic [1:0]  status;
    logic        cs_n;
    logic        sclk;
    logic        mosi;
    logic        miso = 1'b0;

    always #4 clk = ~clk;

    tpm_spi_txn #(
        .CLK_DIV(CLK_DIV), .MAX_POLLS(MAX_POLLS), .MAX_LEN(MAX_LEN)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_ready(req_ready),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .status(status),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard queues
    logic [7:0] exp_mosi[$];
    string      exp_mosi_tag[$];
    logic [7:0] exp_rd[$];
    logic [1:0] exp_stat[$];
    string      exp_stat_tag[$];

    // target model
    bit         sl_rdy;
    int         sl_wait;
    logic [7:0] sl_rd[0:127];
    int         sl_idx, sl_bit;
    logic [7:0] sl_sh;
    int         cs_falls = 0;

    function automatic logic [7:0] resp(input int idx);
        int dstart;
        dstart = sl_rdy ? 4 : 4 + sl_wait + 1;
        if (idx < 3) return 8'h00;
        if (idx == 3) return sl_rdy ? 8'h01 : 8'hFE;
        if (idx < dstart) return ((idx - 4) < sl_wait) ? 8'hFE : 8'h01;
        if (idx - dstart < 128) return sl_rd[idx - dstart];
        return 8'h00;
    endfunction

    always @(negedge cs_n) begin
        cs_falls++;
        sl_idx = 0;
        sl_bit = 0;
        miso = resp(0)[7];
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            sl_sh = {sl_sh[6:0], mosi};
            sl_bit++;
            if (sl_bit == 8) begin
                if (exp_mosi.size() == 0) begin
                    chk(1'b0, "R2 unexpected MOSI byte", sl_sh, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_mosi.pop_front();
                    t = exp_mosi_tag.pop_front();
                    chk(sl_sh == e, t, sl_sh, e);
                end
                sl_idx++;
                sl_bit = 0;
            end
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) miso = resp(sl_idx)[7 - sl_bit];
    end

    // write payload source
    logic [7:0] wbuf[0:127];
    int  wr_idx = 0, wr_n = 0;
    bit  wr_pend = 1'b0;
    always @(negedge clk) begin
        if (wr_pend) wr_idx++;
        wr_valid = (wr_idx < wr_n);
        wr_data  = (wr_idx < wr_n) ? wbuf[wr_idx] : 8'h00;
        wr_pend  = wr_valid && wr_ready;
    end

    // monitors
    int done_cnt = 0;
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_rd.size() == 0) chk(1'b0, "R8 unexpected rd_valid", rd_data, 0);
            else begin
                logic [7:0] e;
                e = exp_rd.pop_front();
                chk(rd_data == e, "R8 read byte", rd_data, e);
            end
        end
        if (!rst && done) begin
            done_cnt++;
            if (exp_stat.size() == 0) chk(1'b0, "R10 unexpected done", status, 0);
            else begin
                logic [1:0] e;
                string t;
                e = exp_stat.pop_front();
                t = exp_stat_tag.pop_front();
                chk(status == e, t, status, e);
                chk(cs_n == 1'b1, "R9 cs released with done", cs_n, 1);
            end
        end
    end

    task automatic run_txn(input bit wr, input logic [15:0] addr, input int len,
                           input bit rdy, input int nwait);
        int  falls0, dc0, polls, guard;
        bit  bad, tmo;
        logic [7:0] lm1;
        bad = (len == 0) || (len > MAX_LEN);
        falls0 = cs_falls;
        dc0 = done_cnt;
        sl_rdy = rdy;
        sl_wait = nwait;
        wr_n = 0;
        wr_idx = 0;
        if (bad) begin
            exp_stat.push_back(2'b01); exp_stat_tag.push_back("R3 bad length status");
        end else begin
            lm1 = 8'(len - 1);
            exp_mosi.push_back({~wr, lm1[6:0]}); exp_mosi_tag.push_back("R1 header byte 0");
            exp_mosi.push_back(8'hD4);           exp_mosi_tag.push_back("R2 header prefix");
            exp_mosi.push_back(addr[15:8]);      exp_mosi_tag.push_back("R2 address high");
            exp_mosi.push_back(addr[7:0]);       exp_mosi_tag.push_back("R2 address low");
            tmo = !rdy && (nwait >= MAX_POLLS);
            polls = rdy ? 0 : (tmo ? MAX_POLLS : nwait + 1);
            for (int i = 0; i < polls; i++) begin
                exp_mosi.push_back(8'h00);
                exp_mosi_tag.push_back(rdy ? "R4 poll byte" : "R5 poll byte");
            end
            if (tmo) begin
                exp_stat.push_back(2'b10); exp_stat_tag.push_back("R6 timeout status");
            end else begin
                for (int i = 0; i < len; i++) begin
                    if (wr) begin
                        wbuf[i] = 8'(addr[7:0] + 8'(i * 37) + 8'h5A);
                        exp_mosi.push_back(wbuf[i]); exp_mosi_tag.push_back("R7 write payload");
                    end else begin
                        sl_rd[i] = 8'(addr[15:8] ^ 8'(i * 13 + 3));
                        exp_rd.push_back(sl_rd[i]);
                        exp_mosi.push_back(8'h00); exp_mosi_tag.push_back("R8 read filler");
                    end
                end
                if (wr) wr_n = len;
                exp_stat.push_back(2'b00); exp_stat_tag.push_back("R10 success status");
            end
        end
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 idle before request", req_ready, 1);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_len   = 8'(len);
        @(negedge clk);
        req_valid = 1'b0;
        if (!bad) chk(req_ready == 1'b0, "R10 busy during request", req_ready, 0);
        guard = 0;
        while (done_cnt == dc0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
        chk(done_cnt == dc0 + 1, "R10 one done per request", done_cnt - dc0, 1);
        chk(cs_falls == falls0 + (bad ? 0 : 1), bad ? "R3 no chip select" : "R9 one chip select",
            cs_falls - falls0, bad ? 0 : 1);
        chk(exp_mosi.size() == 0, "R7 MOSI byte count", exp_mosi.size(), 0);
        chk(exp_rd.size() == 0, "R8 read byte count", exp_rd.size(), 0);
        if (wr && !bad) chk(wr_idx == wr_n, "R7 write bytes taken", wr_idx, wr_n);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R9 idle link", {cs_n, sclk}, 2'b10);
        exp_mosi.delete(); exp_mosi_tag.delete(); exp_rd.delete();
        exp_stat.delete(); exp_stat_tag.delete();
        wr_n = 0; wr_idx = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1, "R9 reset chip select", cs_n, 1);
        chk(sclk == 1'b0, "R9 reset sclk", sclk, 0);
        chk(req_ready == 1'b1 && done == 1'b0, "R10 reset idle", {req_ready, done}, 2'b10);

        run_txn(1'b1, 16'h0F00, 1, 1'b1, 0);          // R4 write, no wait
        run_txn(1'b0, 16'h0F18, 4, 1'b0, 2);          // R5 read, two waits
        run_txn(1'b0, 16'h0024, 2, 1'b1, 0);          // R8 read, no wait
        run_txn(1'b1, 16'hA5C3, 128, 1'b0, 1);        // R1 max length write
        run_txn(1'b0, 16'h1234, 3, 1'b0, MAX_POLLS - 1); // R5 last permitted poll
        run_txn(1'b1, 16'h4321, 2, 1'b0, MAX_POLLS);  // R6 timeout
        run_txn(1'b0, 16'h0001, 129, 1'b1, 0);        // R3 too long
        run_txn(1'b1, 16'h0002, 0, 1'b1, 0);          // R3 zero length
        run_txn(1'b0, 16'hFFFF, 1, 1'b1, 0);          // R1 read single byte

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule